// File: doc/BRIEF.md
# Configuration Wake-up Sequencer

This block wakes a programmable device once its configuration image has been loaded. After reset it counts configuration clock edges. When that count equals a supplied length value and the configuration store reports that it is full, a start stage (Q0) is set. A one, held once set, then ripples through four further stages, Q1 to Q4. Three wake-up events each take their timing from a selectable stage: releasing the open-drain done line, switching the configuration pins over to user I/O, and lifting the global set/reset.

The stages after Q0 can run from the configuration clock or from a user clock. When the user clock is chosen, the start bit crosses into the user domain through a two-flop synchronizer. Only the I/O and set/reset events follow the user clock. The done release always stays on the configuration clock. As a result, a device whose user clock never runs still releases done, while its I/O stays dormant.

In the mode synchronized to done, the done line as read back from the pin is the wired-AND of every driver on it, and entry into Q3 waits until that line reads high. Holding the line low from outside therefore freezes the sequence. In the free mode the line is ignored.

Top module: `cfg_wakeup_seq`

## Requirements
- R1: While `rst_n` is low (asynchronous), `done_rel` is 0, `io_active` is 0 and `gsr_active` is 1, including when reset arrives in the middle of a sequence.
- R2: The internal reset is released on the second `cfg_clk` rising edge after `rst_n` rises. The count is 0 at the first edge after that, and rises by one per edge until it equals `len_count`. Q0 sets on the first edge at which the count equals `len_count` and `mem_full` is 1. Counting edges from the release of `rst_n`, that is edge max(3+len_count, first edge with `mem_full` high).
- R3: With the configuration clock selected (`use_usr_clk`=0) and no stall, stage Qk sets exactly k `cfg_clk` edges after Q0.
- R4: Tap code c (0..3) on `done_tap`, `io_tap` or `gsr_tap` selects stage Q(c+1). `done_rel` and `io_active` are 1 once their stage is set. `gsr_active` is 0 once its stage is set. With codes 0, 1, 2 the events occur in the order done, I/O, set/reset release, one clock apart.
- R5: `use_usr_clk`, `sync_done` and the three tap codes are captured only while the internal configuration-domain reset is active. Changes after that have no effect until the next reset.
- R6: With `sync_done`=1, Q3 is not set on an edge where `done_pin_in` is 0. The sequence stalls there until the pin reads 1.
- R7: With `sync_done`=0, `done_pin_in` has no effect on any output.
- R8: With `use_usr_clk`=1, `done_rel` keeps the configuration-clock timing of R3. Q1 to Q4 for `io_active` and `gsr_active` follow `usr_clk` after a two-flop synchronizer. I/O activates after done is released, and set/reset is released one user clock after I/O with codes 1 and 2.
- R9: With `use_usr_clk`=1 and `usr_clk` stopped, `done_rel` still rises on schedule while `io_active` stays 0 and `gsr_active` stays 1.
- R10: Once released, `done_rel`, `io_active` and the deasserted `gsr_active` hold until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| usr_clk | input | 1 | Optional user clock for stages Q1 to Q4 |
| rst_n | input | 1 | Asynchronous active-low reset (start of load) |
| mem_full | input | 1 | Configuration store full |
| len_count | input | CNT_W | Length value compared against the clock count |
| use_usr_clk | input | 1 | 1: I/O and set/reset stages on `usr_clk` |
| sync_done | input | 1 | 1: Q3 entry gated by `done_pin_in` |
| done_tap | input | 2 | Stage code for done release |
| io_tap | input | 2 | Stage code for I/O activation |
| gsr_tap | input | 2 | Stage code for set/reset release |
| done_pin_in | input | 1 | Wired-AND done level read from the pad |
| done_rel | output | 1 | 1 = stop pulling done low |
| io_active | output | 1 | 1 = user I/O enabled |
| gsr_active | output | 1 | 1 = global set/reset held |

## Verification
The properties assume that mode and tap inputs change only while reset is active, or that they are ignored after it. They also assume that `done_pin_in` and `mem_full` move away from the `cfg_clk` rising edge. The stall property treats the pin as already sampled in the configuration domain.

The stimulus drives every input on the falling edge of `cfg_clk`. After the internal reset has released, it deliberately scrambles the mode and tap inputs, which tests that they are ignored. In user-clock runs the pin is held high, so it never changes near a `usr_clk` edge.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int CWS_TAP_W    = 2;
  localparam int CWS_NSTG     = 1 << CWS_TAP_W;  // stages after Q0
  localparam int CWS_GATE_STG = 3;               // stage gated by done pin

  typedef struct packed {
    logic                 use_usr;
    logic                 sync_done;
    logic [CWS_TAP_W-1:0] done_tap;
    logic [CWS_TAP_W-1:0] io_tap;
    logic [CWS_TAP_W-1:0] gsr_tap;
  } cws_cfg_t;

  function automatic logic tap_pick(input logic [CWS_NSTG-1:0] stg,
                                    input logic [CWS_TAP_W-1:0] tap);
    return stg[tap];
  endfunction
endpackage

// File: rtl/cws_rst_sync.sv
module cws_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] ff_q;
  logic [1:0] ff_nx;

  assign ff_nx = {ff_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_nx;
  end

  assign rst_sync_n = ff_q[1];
endmodule

// File: rtl/cws_len_counter.sv
module cws_len_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] len,
  input  logic             mem_full,
  output logic             q0
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             q0_q, q0_nx;
  logic             hit;
  logic             en;

  assign hit = (cnt_q == len);
  assign en  = ~q0_q;

  always_comb begin
    cnt_nx = cnt_q;
    if (!hit) cnt_nx = cnt_q + 1'b1;
    q0_nx  = q0_q | (hit & mem_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q0_q  <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_nx;
      q0_q  <= q0_nx;
    end
  end

  assign q0 = q0_q;
endmodule

// File: rtl/cws_stage_chain.sv
module cws_stage_chain #(
  parameter int NSTG     = 4,
  parameter int GATE_STG = 3,
  parameter bit SYNC_IN  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed,
  input  logic          gate_en,
  input  logic          pin_ok,
  output logic [NSTG:1] stg
);
  logic          seed_s;
  logic [NSTG:1] stg_q, stg_nx, prev;
  logic          en;

  generate
    if (SYNC_IN) begin : g_sync
      logic [1:0] sff_q, sff_nx;
      assign sff_nx = {sff_q[0], seed};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sff_q <= '0;
        else        sff_q <= sff_nx;
      end
      assign seed_s = sff_q[1];
    end else begin : g_direct
      assign seed_s = seed;
    end
  endgenerate

  assign prev = {stg_q[NSTG-1:1], seed_s};
  assign en   = seed_s & ~stg_q[NSTG];

  always_comb begin
    for (int i = 1; i <= NSTG; i++) begin
      logic adv;
      adv = prev[i];
      if (i == GATE_STG) adv = adv & (~gate_en | pin_ok);
      stg_nx[i] = stg_q[i] | adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stg_q <= '0;
    else if (en) stg_q <= stg_nx;
  end

  assign stg = stg_q;
endmodule

// File: rtl/cfg_wakeup_seq.sv
module cfg_wakeup_seq
  import cws_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 cfg_clk,
  input  logic                 usr_clk,
  input  logic                 rst_n,
  input  logic                 mem_full,
  input  logic [CNT_W-1:0]     len_count,
  input  logic                 use_usr_clk,
  input  logic                 sync_done,
  input  logic [CWS_TAP_W-1:0] done_tap,
  input  logic [CWS_TAP_W-1:0] io_tap,
  input  logic [CWS_TAP_W-1:0] gsr_tap,
  input  logic                 done_pin_in,
  output logic                 done_rel,
  output logic                 io_active,
  output logic                 gsr_active
);
  logic              rst_cfg_n, rst_usr_n;
  cws_cfg_t          cfg_q, cfg_in;
  logic              q0;
  logic              sync_on;
  logic [CWS_NSTG:1] cfg_stg, usr_stg, ev_stg;

  cws_rst_sync u_rst_cfg (.clk(cfg_clk), .rst_n(rst_n), .rst_sync_n(rst_cfg_n));
  cws_rst_sync u_rst_usr (.clk(usr_clk), .rst_n(rst_n), .rst_sync_n(rst_usr_n));

  always_comb begin
    cfg_in.use_usr   = use_usr_clk;
    cfg_in.sync_done = sync_done;
    cfg_in.done_tap  = done_tap;
    cfg_in.io_tap    = io_tap;
    cfg_in.gsr_tap   = gsr_tap;
  end

  // captured only while the configuration domain is held in reset
  always_ff @(posedge cfg_clk) begin
    if (!rst_cfg_n) cfg_q <= cfg_in;
  end

  assign sync_on = cfg_q.sync_done;

  cws_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(cfg_clk), .rst_n(rst_cfg_n), .len(len_count),
    .mem_full(mem_full), .q0(q0)
  );

  cws_stage_chain #(.NSTG(CWS_NSTG), .GATE_STG(CWS_GATE_STG), .SYNC_IN(1'b0)) u_cfg_chain (
    .clk(cfg_clk), .rst_n(rst_cfg_n), .seed(q0),
    .gate_en(sync_on), .pin_ok(done_pin_in), .stg(cfg_stg)
  );

  cws_stage_chain #(.NSTG(CWS_NSTG), .GATE_STG(CWS_GATE_STG), .SYNC_IN(1'b1)) u_usr_chain (
    .clk(usr_clk), .rst_n(rst_usr_n), .seed(q0),
    .gate_en(sync_on), .pin_ok(done_pin_in), .stg(usr_stg)
  );

  assign ev_stg     = cfg_q.use_usr ? usr_stg : cfg_stg;
  assign done_rel   = tap_pick(cfg_stg, cfg_q.done_tap);
  assign io_active  = tap_pick(ev_stg, cfg_q.io_tap);
  assign gsr_active = ~tap_pick(ev_stg, cfg_q.gsr_tap);
endmodule

// File: rtl/cfg_wakeup_seq_chk.sv
module cfg_wakeup_seq_chk
  import cws_pkg::*;
(
  input logic              cfg_clk,
  input logic              rst_n,
  input logic              rst_cfg_n,
  input logic              mem_full,
  input logic              q0,
  input logic [CWS_NSTG:1] cfg_stg,
  input logic              sync_on,
  input logic              done_pin_in,
  input logic              done_rel,
  input logic              io_active,
  input logic              gsr_active
);
  always @(posedge cfg_clk) begin
    if (rst_n === 1'b0) begin
      p_reset_outputs_r1: assert (!done_rel && !io_active && gsr_active)
        else $error("reset outputs wrong");
    end
  end

  p_start_needs_full_r2: assert property (@(posedge cfg_clk) disable iff (!rst_cfg_n)
    $rose(q0) |-> $past(mem_full));

  p_stage_step_r3: assert property (@(posedge cfg_clk) disable iff (!rst_cfg_n)
    $rose(cfg_stg[2]) |-> $past(cfg_stg[1]));

  p_stall_r6: assert property (@(posedge cfg_clk) disable iff (!rst_cfg_n)
    (sync_on && !done_pin_in && !cfg_stg[CWS_GATE_STG]) |=> !cfg_stg[CWS_GATE_STG]);

  p_done_hold_r10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    done_rel |=> done_rel);

  p_io_hold_r10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    io_active |=> io_active);

  p_gsr_hold_r10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !gsr_active |=> !gsr_active);
endmodule

bind cfg_wakeup_seq cfg_wakeup_seq_chk u_chk (
  .cfg_clk(cfg_clk), .rst_n(rst_n), .rst_cfg_n(rst_cfg_n),
  .mem_full(mem_full), .q0(q0), .cfg_stg(cfg_stg), .sync_on(sync_on),
  .done_pin_in(done_pin_in), .done_rel(done_rel),
  .io_active(io_active), .gsr_active(gsr_active)
);

// File: tb/cfg_wakeup_seq_bench.sv
module cfg_wakeup_seq_bench;
  localparam int CNT_W = 16;

  logic             cfg_clk, usr_clk, rst_n, mem_full;
  logic [CNT_W-1:0] len_count;
  logic             use_usr_clk, sync_done, done_pin_in;
  logic [1:0]       done_tap, io_tap, gsr_tap;
  logic             done_rel, io_active, gsr_active;
  logic             usr_run;
  int               n_chk, n_fail;

  cfg_wakeup_seq #(.CNT_W(CNT_W)) u_cfg_wakeup_seq (
    .cfg_clk(cfg_clk), .usr_clk(usr_clk), .rst_n(rst_n), .mem_full(mem_full),
    .len_count(len_count), .use_usr_clk(use_usr_clk), .sync_done(sync_done),
    .done_tap(done_tap), .io_tap(io_tap), .gsr_tap(gsr_tap),
    .done_pin_in(done_pin_in), .done_rel(done_rel),
    .io_active(io_active), .gsr_active(gsr_active)
  );

  initial begin
    cfg_clk = 1'b0;
    forever #4 cfg_clk = ~cfg_clk;
  end

  initial begin
    usr_clk = 1'b0;
    forever begin
      #6;
      if (usr_run) usr_clk = ~usr_clk;
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, got, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // edge (counted from rst_n release) on which stage k sets, configuration clock
  function automatic int stage_edge(input int k, input int len, input int mf,
                                    input bit snc, input int p);
    int q0e, s3;
    q0e = max2(3 + len, mf + 1);
    if (k <= 2) return q0e + k;
    s3 = q0e + 3;
    if (snc) s3 = max2(s3, p + 1);
    return (k == 3) ? s3 : s3 + 1;
  endfunction

  task automatic enter_reset();
    @(negedge cfg_clk);
    rst_n = 1'b0;
  endtask

  task automatic run_trial(input int len, input int mf, input bit snc, input int p,
                           input logic [1:0] dt, input logic [1:0] it, input logic [1:0] gt,
                           input bit scramble, input string tag);
    int last;
    enter_reset();
    use_usr_clk = 1'b0; sync_done = snc;
    done_tap = dt; io_tap = it; gsr_tap = gt;
    len_count = CNT_W'(len);
    mem_full = (mf == 0); done_pin_in = (p == 0);
    repeat (3) @(negedge cfg_clk);
    chk(done_rel, 1'b0, "R1", "done in reset");
    chk(io_active, 1'b0, "R1", "io in reset");
    chk(gsr_active, 1'b1, "R1", "gsr in reset");
    rst_n = 1'b1;
    last = stage_edge(4, len, mf, snc, p) + 3;
    for (int e = 1; e <= last; e++) begin
      @(negedge cfg_clk);
      chk(done_rel, e >= stage_edge(int'(dt) + 1, len, mf, snc, p), tag, "done_rel");
      chk(io_active, e >= stage_edge(int'(it) + 1, len, mf, snc, p), tag, "io_active");
      chk(gsr_active, !(e >= stage_edge(int'(gt) + 1, len, mf, snc, p)), tag, "gsr_active");
      mem_full = (e >= mf);
      done_pin_in = (e >= p);
      if (scramble && e >= 2) begin
        done_tap = 2'($urandom); io_tap = 2'($urandom); gsr_tap = 2'($urandom);
        sync_done = 1'($urandom); use_usr_clk = 1'($urandom);
      end
    end
  endtask

  task automatic run_usr(input bit on, input int len);
    int io_e, gsr_e;
    string tag;
    tag = on ? "R8" : "R9";
    enter_reset();
    usr_run = on;
    use_usr_clk = 1'b1; sync_done = 1'b0;
    done_tap = 2'd0; io_tap = 2'd1; gsr_tap = 2'd2;
    len_count = CNT_W'(len); mem_full = 1'b1; done_pin_in = 1'b1;
    repeat (3) @(negedge cfg_clk);
    rst_n = 1'b1;
    io_e = -1; gsr_e = -1;
    for (int e = 1; e <= 60; e++) begin
      @(negedge cfg_clk);
      chk(done_rel, e >= len + 4, tag, "done_rel cfg timing");
      if (io_active && io_e < 0) io_e = e;
      if (!gsr_active && gsr_e < 0) gsr_e = e;
      if (!on) begin
        chk(io_active, 1'b0, "R9", "io with stopped user clock");
        chk(gsr_active, 1'b1, "R9", "gsr with stopped user clock");
      end
    end
    if (on) begin
      chk(io_e > len + 4, 1'b1, "R8", "io after done");
      chk(gsr_e >= io_e && gsr_e <= io_e + 2, 1'b1, "R8", "gsr one user clock after io");
    end
    usr_run = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge cfg_clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd4242));
    usr_run = 1'b1;
    rst_n = 1'b0; mem_full = 1'b0; len_count = '0;
    use_usr_clk = 1'b0; sync_done = 1'b0; done_pin_in = 1'b1;
    done_tap = 2'd0; io_tap = 2'd1; gsr_tap = 2'd2;

    // R3 and R4 default ordering, then R10 hold and R1 asynchronous reset
    run_trial(5, 0, 1'b0, 0, 2'd0, 2'd1, 2'd2, 1'b0, "R3");
    repeat (5) begin
      @(negedge cfg_clk);
      chk(done_rel, 1'b1, "R10", "done held");
      chk(io_active, 1'b1, "R10", "io held");
      chk(gsr_active, 1'b0, "R10", "gsr held released");
    end
    #2 rst_n = 1'b0;
    #1;
    chk(done_rel, 1'b0, "R1", "async reset done");
    chk(io_active, 1'b0, "R1", "async reset io");
    chk(gsr_active, 1'b1, "R1", "async reset gsr");

    run_trial(0, 12, 1'b0, 0, 2'd0, 2'd1, 2'd2, 1'b0, "R2");
    run_trial(9, 3, 1'b0, 0, 2'd0, 2'd1, 2'd2, 1'b0, "R2");
    run_trial(2, 0, 1'b0, 0, 2'd3, 2'd0, 2'd1, 1'b0, "R4");
    run_trial(3, 0, 1'b1, 25, 2'd0, 2'd2, 2'd3, 1'b0, "R6");
    run_trial(4, 0, 1'b0, 100000, 2'd1, 2'd2, 2'd3, 1'b0, "R7");

    for (int t = 0; t < 40; t++) begin
      run_trial(int'($urandom_range(0, 20)), int'($urandom_range(0, 25)),
                1'($urandom), int'($urandom_range(0, 30)),
                2'($urandom), 2'($urandom), 2'($urandom), 1'b1, "R5");
    end

    run_usr(1'b1, 4);
    run_usr(1'b0, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule